// File: doc/BRIEF.md
# Asynchronous start-stop data stripper

This block takes an asynchronous serial line and recovers each character from it by oversampling at sixteen times the bit rate. A character is a low start bit, eight or nine data bits sent least significant bit first, and at least one high stop bit. The framing bits are removed. The data bits go into a four-word FIFO, which a downstream synchronous transmitter drains one word at a time with a pop strobe.

The sixteen-times sample tick comes from one of two sources. When the 3-bit rate select is nonzero, an internal divider derived from the system clock produces it. When the rate select is all zeros, the tick comes from the rising edges of an external clock pin.

A line break is a character in which every data bit and the stop position are sampled low. A break is not written into the FIFO. It sets a sticky flag for the synchronous side, and the flag stays set until the line is high again and the flag is acknowledged. A character that arrives when the FIFO is full is dropped, and a sticky overrun bit is set.

Top module: `async_stripper`

## Requirements
- R1: After reset, `not_empty_o`, `break_o` and `overrun_o` are 0.
- R2: With `wlen9_i`=0, a character with 8 data bits sent LSB first and a high stop bit appears at `head_o[7:0]`, and `head_o[8]` is 0.
- R3: With `wlen9_i`=1, 9 data bits are taken LSB first, and bit 8 appears at `head_o[8]`.
- R4: A low pulse on the line that has ended before sample 8 of 16 after the falling edge is ignored, and no word is written.
- R5: When `rate_sel_i`=s is nonzero, one sample tick occurs every BASE_DIV<<(s-1) clocks. A bit lasts 16 ticks, and each data bit is taken at the middle of its bit.
- R6: When `rate_sel_i`=0, each rising edge of `ext_clk_i` is one sample tick, and the divider produces no ticks.
- R7: The FIFO holds four words in arrival order. `head_o` shows the oldest word, and each `pop_i` pulse removes that word.
- R8: A character that completes while four words are held is dropped, and `overrun_o` then stays at 1 until reset.
- R9: A character whose data bits and stop position are all low sets `break_o` and writes no word.
- R10: `break_o` clears only in a cycle in which `break_ack_i` is 1 and the line is high. An acknowledge while the line is low has no effect.
- R11: A character with a low stop bit and nonzero data is discarded and does not set `break_o`.
- R12: A `pop_i` pulse while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| wlen9_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rate_sel_i | input | 3 | Divider select; 0 selects the external clock |
| ext_clk_i | input | 1 | External sixteen-times sample clock |
| pop_i | input | 1 | Removes the head word from the FIFO |
| break_ack_i | input | 1 | Acknowledges the break flag |
| head_o | output | 9 | Oldest word held in the FIFO |
| not_empty_o | output | 1 | FIFO holds at least one word |
| break_o | output | 1 | Sticky break flag |
| overrun_o | output | 1 | Sticky FIFO overrun flag |

## Verification
A wrong sample counter or bit index produces shifted or duplicated data bits in `head_o`. This shows one character time after the fault, at the next pop. A stuck receiver state shows as `not_empty_o` failing to rise within two bit times of a stop bit, or as a break or overrun flag that rises when it should not. A FIFO pointer fault shows only when words are popped: words come out in the wrong order, or a stale word appears after an overflow. The bench therefore drains every word it writes.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_STOP, ST_WAIT_HIGH
  } rx_state_e;
endpackage

// File: rtl/ds_tick_gen.sv
module ds_tick_gen #(
  parameter int unsigned BASE_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] rate_sel_i,
  input  logic       ext_clk_i,
  output logic       tick_o
);
  localparam int unsigned CW = $clog2(BASE_DIV << 7);

  logic [CW-1:0] div_w, cnt_q;
  logic [2:0]    ext_q;
  logic          int_tick;

  assign div_w    = CW'(BASE_DIV) << (rate_sel_i - 3'd1);
  assign int_tick = (rate_sel_i != 3'd0) && (cnt_q >= div_w - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ext_q <= '0;
    end else begin
      ext_q <= {ext_q[1:0], ext_clk_i};
      if (rate_sel_i == 3'd0 || int_tick) cnt_q <= '0;
      else                                cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tick_o = (rate_sel_i == 3'd0) ? (ext_q[1] & ~ext_q[2]) : int_tick;

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i != 3'd0 && $stable(rate_sel_i) && tick_o) |=> !tick_o); // R5
endmodule

// File: rtl/ds_framer.sv
module ds_framer
  import ds_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rxd_i,
  input  logic  tick_i,
  input  logic  wlen9_i,
  input  logic  break_ack_i,
  output logic  push_o,
  output word_t word_o,
  output logic  break_o
);
  rx_state_e state_q;
  logic [1:0] rx_sync_q;
  logic       rx_s, len9_q, push_q, brk_q;
  logic [3:0] cnt_q, bit_idx_q;
  word_t      sh_q, word_q;

  assign rx_s = rx_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sync_q <= 2'b11;
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_idx_q <= '0;
      len9_q    <= 1'b0;
      sh_q      <= '0;
      word_q    <= '0;
      push_q    <= 1'b0;
      brk_q     <= 1'b0;
    end else begin
      rx_sync_q <= {rx_sync_q[0], rxd_i};
      push_q    <= 1'b0;
      if (brk_q && break_ack_i && rx_s) brk_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rx_s) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: begin
            if (cnt_q == 4'd7) begin
              cnt_q <= '0;
              if (!rx_s) begin      // confirmed start at mid-bit
                state_q   <= ST_DATA;
                bit_idx_q <= '0;
                sh_q      <= '0;
                len9_q    <= wlen9_i;
              end else begin
                state_q <= ST_IDLE; // glitch
              end
            end else cnt_q <= cnt_q + 4'd1;
          end
          ST_DATA: begin
            if (cnt_q == 4'd15) begin
              cnt_q <= '0;
              sh_q[bit_idx_q] <= rx_s;
              if (bit_idx_q == (len9_q ? 4'd8 : 4'd7)) state_q <= ST_STOP;
              else bit_idx_q <= bit_idx_q + 4'd1;
            end else cnt_q <= cnt_q + 4'd1;
          end
          ST_STOP: begin
            if (cnt_q == 4'd15) begin
              cnt_q <= '0;
              if (rx_s) begin
                push_q  <= 1'b1;
                word_q  <= sh_q;
                state_q <= ST_IDLE;
              end else begin
                if (sh_q == '0) brk_q <= 1'b1;
                state_q <= ST_WAIT_HIGH;
              end
            end else cnt_q <= cnt_q + 4'd1;
          end
          ST_WAIT_HIGH: if (rx_s) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign push_o  = push_q;
  assign word_o  = word_q;
  assign break_o = brk_q;

  AST_PUSH_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_q |-> $past(state_q == ST_STOP)); // R2
  AST_BRK_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_q) |-> !push_q); // R9
  AST_BRK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk_q) |-> $past(break_ack_i && rx_s)); // R10
endmodule

// File: rtl/ds_fifo.sv
module ds_fifo
  import ds_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  word_t data_i,
  input  logic  pop_i,
  output word_t head_o,
  output logic  not_empty_o,
  output logic  overrun_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  word_t         mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;
  logic          full, do_push, do_pop, ovr_q;

  assign full    = (count_q == CW'(DEPTH));
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && (count_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      ovr_q   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i && full) ovr_q <= 1'b1;
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      end
      if (do_pop) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      if (do_push && !do_pop)      count_q <= count_q + CW'(1);
      else if (do_pop && !do_push) count_q <= count_q - CW'(1);
    end
  end

  assign head_o      = mem_q[rd_q];
  assign not_empty_o = (count_q != '0);
  assign overrun_o   = ovr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q); // R8
  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && count_q == '0) |=> (count_q == '0)); // R12
endmodule

// File: rtl/async_stripper.sv
module async_stripper
  import ds_pkg::*;
#(
  parameter int unsigned BASE_DIV   = 4,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              wlen9_i,
  input  logic [2:0]        rate_sel_i,
  input  logic              ext_clk_i,
  input  logic              pop_i,
  input  logic              break_ack_i,
  output logic [WORD_W-1:0] head_o,
  output logic              not_empty_o,
  output logic              break_o,
  output logic              overrun_o
);
  logic  tick, push;
  word_t word;

  ds_tick_gen #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk_i, .rst_ni, .rate_sel_i, .ext_clk_i, .tick_o(tick)
  );

  ds_framer u_framer (
    .clk_i, .rst_ni, .rxd_i, .tick_i(tick), .wlen9_i, .break_ack_i,
    .push_o(push), .word_o(word), .break_o
  );

  ds_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .data_i(word), .pop_i,
    .head_o, .not_empty_o, .overrun_o
  );
endmodule

// File: tb/async_stripper_tb.sv
module async_stripper_tb;
  localparam int BASE_DIV = 4;
  localparam int EXT_HALF = 3;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       rxd = 1'b1, wlen9 = 1'b0, ext_clk = 1'b0, ext_en = 1'b0;
  logic       pop = 1'b0, ack = 1'b0;
  logic [2:0] rate_sel = 3'd1;
  logic [8:0] head;
  logic       not_empty, brk, ovr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  async_stripper #(.BASE_DIV(BASE_DIV)) u_dut (
    .clk_i(clk), .rst_ni, .rxd_i(rxd), .wlen9_i(wlen9), .rate_sel_i(rate_sel),
    .ext_clk_i(ext_clk), .pop_i(pop), .break_ack_i(ack),
    .head_o(head), .not_empty_o(not_empty), .break_o(brk), .overrun_o(ovr)
  );

  initial forever begin
    repeat (EXT_HALF) @(negedge clk);
    if (ext_en) ext_clk = ~ext_clk; else ext_clk = 1'b0;
  end

  function automatic int bit_cycles(input logic [2:0] sel);
    if (sel == 3'd0) return 16 * 2 * EXT_HALF;
    return 16 * (BASE_DIV << (sel - 1));
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] d, input bit nine, input bit stop_hi);
    int bc = bit_cycles(rate_sel);
    rxd = 1'b0; wait_clk(bc);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin rxd = d[i]; wait_clk(bc); end
    rxd = stop_hi; wait_clk(bc);
    rxd = 1'b1; wait_clk(2 * bc);
  endtask

  task automatic do_pop();
    pop = 1'b1; wait_clk(1); pop = 1'b0; wait_clk(1);
  endtask

  task automatic send_and_check(input logic [8:0] d, input bit nine, input string req);
    wlen9 = nine;
    send(d, nine, 1'b1);
    chk(req, int'(not_empty), 1);
    chk(req, int'(head), int'(nine ? d : {1'b0, d[7:0]}));
    do_pop();
  endtask

  initial begin
    wait_clk(200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    wait_clk(4); rst_ni = 1'b1; wait_clk(4);
    // R1 reset state
    chk("R1", int'(not_empty), 0);
    chk("R1", int'(brk), 0);
    chk("R1", int'(ovr), 0);

    // R2 8-bit, R3 9-bit
    send_and_check(9'h0A5, 1'b0, "R2");
    send_and_check(9'h1FF, 1'b0, "R2");
    send_and_check(9'h13C, 1'b1, "R3");
    send_and_check(9'h0C3, 1'b1, "R3");

    // R12 pop on empty
    do_pop();
    chk("R12", int'(not_empty), 0);

    // R4 glitch shorter than half a bit
    rxd = 1'b0; wait_clk(3 * BASE_DIV); rxd = 1'b1;
    wait_clk(3 * bit_cycles(rate_sel));
    chk("R4", int'(not_empty), 0);

    // R5 other divider rates
    rate_sel = 3'd2; send_and_check(9'h05A, 1'b0, "R5");
    rate_sel = 3'd3; send_and_check(9'h081, 1'b0, "R5");

    // R6 external sample clock
    rate_sel = 3'd0; ext_en = 1'b0;
    send(9'h033, 1'b0, 1'b1);
    chk("R6", int'(not_empty), 0);
    ext_en = 1'b1; wait_clk(20);
    send_and_check(9'h0E7, 1'b0, "R6");
    ext_en = 1'b0; rate_sel = 3'd1; wait_clk(20);

    // R7 order, R8 overflow
    wlen9 = 1'b0;
    for (int i = 0; i < 5; i++) send(9'(8'h11 * (i + 1)), 1'b0, 1'b1);
    chk("R8", int'(ovr), 1);
    for (int i = 0; i < 4; i++) begin
      chk("R7", int'(head), 8'h11 * (i + 1));
      do_pop();
    end
    chk("R8", int'(not_empty), 0);
    chk("R8", int'(ovr), 1);

    // R11 framing error
    send(9'h055, 1'b0, 1'b0);
    chk("R11", int'(not_empty), 0);
    chk("R11", int'(brk), 0);

    // R9 break, R10 clear rule
    rxd = 1'b0; wait_clk(14 * bit_cycles(rate_sel));
    chk("R9", int'(brk), 1);
    chk("R9", int'(not_empty), 0);
    ack = 1'b1; wait_clk(1); ack = 1'b0; wait_clk(2);
    chk("R10", int'(brk), 1);
    rxd = 1'b1; wait_clk(6);
    chk("R10", int'(brk), 1);
    ack = 1'b1; wait_clk(1); ack = 1'b0; wait_clk(2);
    chk("R10", int'(brk), 0);
    wait_clk(2 * bit_cycles(rate_sel));

    // random characters on divider rates
    for (int n = 0; n < 16; n++) begin
      logic [8:0] d = 9'($urandom);
      bit nine = 1'($urandom);
      rate_sel = 3'(1 + ($urandom % 2));
      send_and_check(d, nine, nine ? "R3" : "R2");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule